// File: doc/BRIEF.md
# PRBS Checker Setup Sequencer

This block is a hardware master that turns a transceiver receive channel into a pseudo-random bit sequence checker without software involvement. On a one-cycle start pulse it captures its configuration inputs (logical channel, PCS/PMA interface width, aligner size code and a 40-bit aligner pattern). It then walks a fixed list of accesses on a simple register bus that has an address, write data, read data, read and write strobes and a wait request.

The list has four parts. The block first waits for the reconfiguration engine to report idle. It then names the channel to be reprogrammed and selects the engine mode. After that it edits aligner, synchronization and enable fields, each with a masked read-modify-write that leaves every other bit of the word as it found it. Finally it pulses the channel reset for a programmable time and raises a one-cycle done flag.

Top module: `prbs_chk_cfg_seq`

## Requirements
- R1: After start, the first and only accesses until the engine is idle are reads of address 0x3A; polling continues while read data bit 8 is 1 and ends on the first read with bit 8 equal to 0.
- R2: Next, the captured channel number, zero-extended, is written to address 0x38, and a read-modify-write then sets bits [3:2] of address 0x3A to 2'b01.
- R3: Every field update is a read of the word followed by a write of (old & ~mask) | (value & mask) to the same address, so bits outside the field keep their value.
- R4: The aligner size code goes to 0xA1 bits [10:8]; pattern bits [39:32] go to 0xA1 bits [7:0], bits [31:16] to all of 0xA2, and bits [15:0] to all of 0xA3.
- R5: At 0xA1, bits [15:14], bit 13 and bit 11 are each cleared by a separate read-modify-write, in that order, after the pattern.
- R6: The width input encodes 0 = 8 bits, 1 = 10 bits, 2 = 16 bits, 3 = 20 bits; 0xA4 bit 15 is written 1 for codes 0 and 1 and 0 for codes 2 and 3.
- R7: The block then clears 0xA6 bit 5, 0xB8 bit 13, 0xB9 bit 11 and 0xBA bit 11, in that order, and last sets 0xA0 bit 5 to 1.
- R8: Accesses follow the order of R1 to R7; read and write strobes are never high together; a strobe held while wait request is 1 keeps its address (and write data) until the cycle wait request is 0, which completes the access.
- R9: The channel reset output rises in the cycle after the final write completes and stays high for exactly RST_CYCLES cycles (default 8).
- R10: The done output is high for one cycle, the first cycle after the channel reset falls; the block then accepts a new start.
- R11: A start pulse, or a change of the configuration inputs, while a sequence is in progress has no effect on that sequence and starts no second one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the sequence |
| cfg_chan | input | CH_W | Logical channel number |
| cfg_width | input | 2 | PCS/PMA width code (0:8, 1:10, 2:16, 3:20 bits) |
| cfg_size | input | 3 | Word aligner size code |
| cfg_pattern | input | 40 | Word aligner pattern |
| bus_addr | output | 8 | Register bus address |
| bus_wdata | output | 16 | Register bus write data |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_rdata | input | 16 | Read data, valid when bus_rd is high and bus_wait is low |
| bus_wait | input | 1 | Wait request; holds the current access |
| chan_rst | output | 1 | Channel reset pulse |
| done | output | 1 | One-cycle completion flag |

## Verification
The hardest condition to reach is a read that stalls on wait request while the engine still reports busy, followed by the busy bit clearing on a stalled poll. A second hard condition is a start pulse with changed configuration arriving in the middle of a read-modify-write. The bench models the engine's register file with randomly filled words, a busy bit that clears after a chosen delay, and wait request driven at random with a per-run density from 0 to 60 percent. In one run it pulses start and changes every configuration input partway through. It then checks every field and every untouched bit in the final register image.

// File: rtl/prbs_cfg_pkg.sv
package prbs_cfg_pkg;

  localparam int REG_AW    = 8;
  localparam int REG_DW    = 16;
  localparam int NUM_STEPS = 16;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam int BUSY_BIT  = 8;

  localparam logic [REG_AW-1:0] ADR_ENG_CSR  = 8'h3A;
  localparam logic [REG_AW-1:0] ADR_ENG_CHAN = 8'h38;
  localparam logic [REG_AW-1:0] ADR_RX_EN    = 8'hA0;
  localparam logic [REG_AW-1:0] ADR_ALIGN    = 8'hA1;
  localparam logic [REG_AW-1:0] ADR_PAT_HI   = 8'hA2;
  localparam logic [REG_AW-1:0] ADR_PAT_LO   = 8'hA3;
  localparam logic [REG_AW-1:0] ADR_SYNC     = 8'hA4;
  localparam logic [REG_AW-1:0] ADR_BYTEAL   = 8'hA6;
  localparam logic [REG_AW-1:0] ADR_DWSYNC   = 8'hB8;
  localparam logic [REG_AW-1:0] ADR_DETLAT   = 8'hB9;
  localparam logic [REG_AW-1:0] ADR_CLKPD    = 8'hBA;

  typedef enum logic [1:0] {
    OP_POLL,
    OP_WRITE,
    OP_RMW
  } step_op_e;

  typedef struct packed {
    step_op_e            op;
    logic [REG_AW-1:0]   addr;
    logic [REG_DW-1:0]   mask;
    logic [REG_DW-1:0]   value;
  } step_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NEXT,
    ST_READ,
    ST_WRITE,
    ST_CHRST,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/prbs_cfg_step_rom.sv
module prbs_cfg_step_rom
  import prbs_cfg_pkg::*;
#(
  parameter int CH_W = 10
) (
  input  logic [STEP_W-1:0] step_idx,
  input  logic [CH_W-1:0]   chan,
  input  logic [1:0]        width_sel,
  input  logic [2:0]        size,
  input  logic [39:0]       pattern,
  output step_t             step
);

  localparam int PAD_W = REG_DW - CH_W;

  logic narrow;
  assign narrow = ~width_sel[1];

  always_comb begin
    step.op    = OP_RMW;
    step.addr  = ADR_ENG_CSR;
    step.mask  = '0;
    step.value = '0;
    case (step_idx)
      4'd0: begin
        step.op   = OP_POLL;
        step.addr = ADR_ENG_CSR;
      end
      4'd1: begin
        step.op    = OP_WRITE;
        step.addr  = ADR_ENG_CHAN;
        step.mask  = '1;
        step.value = {{PAD_W{1'b0}}, chan};
      end
      4'd2: begin
        step.addr  = ADR_ENG_CSR;
        step.mask  = 16'h000C;
        step.value = 16'h0004;
      end
      4'd3: begin
        step.addr  = ADR_ALIGN;
        step.mask  = 16'h0700;
        step.value = {5'd0, size, 8'd0};
      end
      4'd4: begin
        step.addr  = ADR_ALIGN;
        step.mask  = 16'h00FF;
        step.value = {8'd0, pattern[39:32]};
      end
      4'd5: begin
        step.addr  = ADR_PAT_HI;
        step.mask  = 16'hFFFF;
        step.value = pattern[31:16];
      end
      4'd6: begin
        step.addr  = ADR_PAT_LO;
        step.mask  = 16'hFFFF;
        step.value = pattern[15:0];
      end
      4'd7: begin
        step.addr = ADR_ALIGN;
        step.mask = 16'hC000;
      end
      4'd8: begin
        step.addr = ADR_ALIGN;
        step.mask = 16'h2000;
      end
      4'd9: begin
        step.addr = ADR_ALIGN;
        step.mask = 16'h0800;
      end
      4'd10: begin
        step.addr  = ADR_SYNC;
        step.mask  = 16'h8000;
        step.value = {narrow, 15'd0};
      end
      4'd11: begin
        step.addr = ADR_BYTEAL;
        step.mask = 16'h0020;
      end
      4'd12: begin
        step.addr = ADR_DWSYNC;
        step.mask = 16'h2000;
      end
      4'd13: begin
        step.addr = ADR_DETLAT;
        step.mask = 16'h0800;
      end
      4'd14: begin
        step.addr = ADR_CLKPD;
        step.mask = 16'h0800;
      end
      default: begin
        step.addr  = ADR_RX_EN;
        step.mask  = 16'h0020;
        step.value = 16'h0020;
      end
    endcase
  end

endmodule

// File: rtl/prbs_cfg_rmw_merge.sv
module prbs_cfg_rmw_merge
  import prbs_cfg_pkg::*;
(
  input  logic [REG_DW-1:0] old_word,
  input  logic [REG_DW-1:0] field_mask,
  input  logic [REG_DW-1:0] field_value,
  output logic [REG_DW-1:0] new_word
);

  always_comb begin
    new_word = (old_word & ~field_mask) | (field_value & field_mask);
  end

  always_comb begin
    a_r3_outside_kept : assert (((new_word ^ old_word) & ~field_mask) == '0)
      else $error("merge changed bits outside the field mask");
  end

endmodule

// File: rtl/prbs_cfg_hold_timer.sv
module prbs_cfg_hold_timer #(
  parameter int HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);

  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == '0);

  always_comb begin
    cnt_en = load | (run & ~expired);
    cnt_d  = load ? LOAD_VAL : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  a_r9_load_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !run)
    else $error("hold timer loaded while running");

endmodule

// File: rtl/prbs_chk_cfg_seq.sv
module prbs_chk_cfg_seq
  import prbs_cfg_pkg::*;
#(
  parameter int CH_W       = 10,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic [1:0]        cfg_width,
  input  logic [2:0]        cfg_size,
  input  logic [39:0]       cfg_pattern,
  output logic [REG_AW-1:0] bus_addr,
  output logic [REG_DW-1:0] bus_wdata,
  output logic              bus_rd,
  output logic              bus_wr,
  input  logic [REG_DW-1:0] bus_rdata,
  input  logic              bus_wait,
  output logic              chan_rst,
  output logic              done
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
  localparam int RCW = $clog2(RST_CYCLES + 1) + 1;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [REG_DW-1:0] wdata_q, wdata_d;
  logic              wdata_en;
  logic              cfg_load;
  logic              tmr_load;
  logic              tmr_expired;

  logic [CH_W-1:0]   chan_q;
  logic [1:0]        width_q;
  logic [2:0]        size_q;
  logic [39:0]       pattern_q;

  step_t             cur;
  logic [REG_DW-1:0] merged;

  prbs_cfg_step_rom #(
    .CH_W (CH_W)
  ) u_rom (
    .step_idx  (step_q),
    .chan      (chan_q),
    .width_sel (width_q),
    .size      (size_q),
    .pattern   (pattern_q),
    .step      (cur)
  );

  prbs_cfg_rmw_merge u_merge (
    .old_word    (bus_rdata),
    .field_mask  (cur.mask),
    .field_value (cur.value),
    .new_word    (merged)
  );

  prbs_cfg_hold_timer #(
    .HOLD (RST_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (tmr_load),
    .run     (state_q == ST_CHRST),
    .expired (tmr_expired)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    wdata_d  = wdata_q;
    wdata_en = 1'b0;
    cfg_load = 1'b0;
    tmr_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          cfg_load = 1'b1;
          step_d   = '0;
          state_d  = ST_READ;
        end
      end
      ST_NEXT: begin
        state_d = (cur.op == OP_WRITE) ? ST_WRITE : ST_READ;
      end
      ST_READ: begin
        if (!bus_wait) begin
          if (cur.op == OP_POLL) begin
            if (!bus_rdata[BUSY_BIT]) begin
              step_d  = step_q + 1'b1;
              state_d = ST_NEXT;
            end
          end else begin
            wdata_d  = merged;
            wdata_en = 1'b1;
            state_d  = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        if (!bus_wait) begin
          if (step_q == LAST_STEP) begin
            tmr_load = 1'b1;
            state_d  = ST_CHRST;
          end else begin
            step_d  = step_q + 1'b1;
            state_d = ST_NEXT;
          end
        end
      end
      ST_CHRST: begin
        if (tmr_expired) begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wdata_q <= '0;
    end else if (wdata_en) begin
      wdata_q <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      chan_q    <= '0;
      width_q   <= '0;
      size_q    <= '0;
      pattern_q <= '0;
    end else if (cfg_load) begin
      chan_q    <= cfg_chan;
      width_q   <= cfg_width;
      size_q    <= cfg_size;
      pattern_q <= cfg_pattern;
    end
  end

  // bus and status outputs
  always_comb begin
    bus_rd    = (state_q == ST_READ);
    bus_wr    = (state_q == ST_WRITE);
    bus_addr  = cur.addr;
    bus_wdata = (cur.op == OP_WRITE) ? cur.value : wdata_q;
    chan_rst  = (state_q == ST_CHRST);
    done      = (state_q == ST_DONE);
  end

  // checks
  logic [RCW-1:0] rst_run_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rst_run_q <= '0;
    end else if (chan_rst) begin
      rst_run_q <= rst_run_q + 1'b1;
    end else begin
      rst_run_q <= '0;
    end
  end

  a_r8_single_strobe : assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_rd && bus_wr))
    else $error("read and write strobes together");

  a_r8_hold_read : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && bus_wait) |=> (bus_rd && $stable(bus_addr)))
    else $error("stalled read dropped or moved");

  a_r8_hold_write : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_wait) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)))
    else $error("stalled write dropped or changed");

  a_r9_rst_after_write : assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(chan_rst) |-> $past(bus_wr && !bus_wait))
    else $error("channel reset without a completed write");

  a_r9_rst_length : assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(chan_rst) |-> (rst_run_q == RCW'(RST_CYCLES)))
    else $error("channel reset length wrong");

  a_r10_done_after_rst : assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> ($past(chan_rst) && !chan_rst))
    else $error("done not right after channel reset");

  a_r10_done_pulse : assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done)
    else $error("done longer than one cycle");

endmodule

// File: tb/prbs_chk_cfg_seq_bench.sv
`timescale 1ns/1ps
module prbs_chk_cfg_seq_bench;

  localparam int CH_W = 10;
  localparam int RSTC = 8;
  localparam int NRMW = 14;
  localparam int LAST_PHASE = 2 + 2 * NRMW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [CH_W-1:0] cfg_chan = '0;
  logic [1:0]  cfg_width = '0;
  logic [2:0]  cfg_size = '0;
  logic [39:0] cfg_pattern = '0;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_rd;
  logic        bus_wr;
  logic [15:0] bus_rdata;
  logic        bus_wait = 1'b0;
  logic        chan_rst;
  logic        done;

  always #2 clk = ~clk;

  prbs_chk_cfg_seq #(.CH_W(CH_W), .RST_CYCLES(RSTC)) u_prbs_chk_cfg_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_chan(cfg_chan),
    .cfg_width(cfg_width), .cfg_size(cfg_size), .cfg_pattern(cfg_pattern),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .bus_wait(bus_wait), .chan_rst(chan_rst), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // register file model
  logic [15:0] regs [0:255];
  logic [15:0] snap [0:255];
  logic [15:0] keep [0:255];
  int busy_left = 0;
  int wait_pct = 0;

  assign bus_rdata = (bus_addr == 8'h3A) ?
    ((regs[8'h3A] & 16'hFEFF) | ((busy_left != 0) ? 16'h0100 : 16'h0000)) :
    regs[bus_addr];

  // expected plan of field edits
  logic [7:0]  pa [0:NRMW-1];
  logic [15:0] pm [0:NRMW-1];
  logic [15:0] pv [0:NRMW-1];
  logic [15:0] exp_chan;

  int phase = 0;
  logic [15:0] last_read = '0;
  int rst_cnt = 0;
  int done_cnt = 0;

  // posedge captures
  logic s_rd = 1'b0, s_wr = 1'b0, s_wait = 1'b0;
  logic [7:0]  s_addr = '0;
  logic [15:0] s_wdata = '0, s_rdata = '0;
  logic p_rd = 1'b0, p_wr = 1'b0, p_wait = 1'b0;
  logic [7:0]  p_addr = '0;
  logic [15:0] p_wdata = '0;

  always @(posedge clk) begin
    s_rd    <= bus_rd;
    s_wr    <= bus_wr;
    s_wait  <= bus_wait;
    s_addr  <= bus_addr;
    s_wdata <= bus_wdata;
    s_rdata <= bus_rdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // cycle-by-cycle reference comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (s_rd || s_wr)
        chk(!(s_rd && s_wr), "R8", "strobes exclusive", {s_rd, s_wr}, 2'b10);
      if (p_rd && p_wait)
        chk(s_rd && s_addr == p_addr, "R8", "stalled read held", {s_rd, s_addr}, {1'b1, p_addr});
      if (p_wr && p_wait)
        chk(s_wr && s_addr == p_addr && s_wdata == p_wdata, "R8", "stalled write held",
            {s_wr, s_addr, s_wdata}, {1'b1, p_addr, p_wdata});
      if ((s_rd || s_wr) && !s_wait) begin
        if (phase == 0) begin
          chk(s_rd && s_addr == 8'h3A, "R1", "poll access", {s_wr, s_addr}, {1'b0, 8'h3A});
          if (!s_rdata[8]) phase = 1;
        end else if (phase == 1) begin
          chk(s_wr && s_addr == 8'h38 && s_wdata == exp_chan, "R2", "channel write",
              {s_wr, s_addr, s_wdata}, {1'b1, 8'h38, exp_chan});
          regs[s_addr] = s_wdata;
          phase = 2;
        end else if (phase < LAST_PHASE) begin
          int k;
          logic [15:0] ev;
          k = (phase - 2) / 2;
          if ((phase % 2) == 0) begin
            chk(s_rd && s_addr == pa[k], "R8", "rmw read order", {s_rd, s_addr}, {1'b1, pa[k]});
            last_read = s_rdata;
          end else begin
            ev = (last_read & ~pm[k]) | (pv[k] & pm[k]);
            chk(s_wr && s_addr == pa[k] && s_wdata == ev, "R3", "rmw write value",
                {s_wr, s_addr, s_wdata}, {1'b1, pa[k], ev});
            regs[s_addr] = s_wdata;
            if (k == NRMW - 1)
              chk(chan_rst == 1'b1, "R9", "reset after last write", chan_rst, 1);
          end
          phase++;
        end else begin
          chk(1'b0, "R8", "access after sequence end", {s_wr, s_addr}, 0);
        end
      end
      if (chan_rst) begin
        rst_cnt++;
      end else if (rst_cnt > 0) begin
        chk(rst_cnt == RSTC, "R9", "reset length", rst_cnt, RSTC);
        chk(done == 1'b1, "R10", "done after reset", done, 1);
        rst_cnt = 0;
      end
      if (done) done_cnt++;
    end
    p_rd = s_rd; p_wr = s_wr; p_wait = s_wait; p_addr = s_addr; p_wdata = s_wdata;
    if (busy_left > 0) busy_left--;
    bus_wait = (($urandom % 100) < wait_pct);
  end

  function automatic void plan_entry(input int i, input logic [7:0] a,
                                     input logic [15:0] m, input logic [15:0] v);
    pa[i] = a; pm[i] = m; pv[i] = v;
  endfunction

  task automatic run_seq(input logic [1:0] w, input logic [CH_W-1:0] ch,
                         input logic [2:0] sz, input logic [39:0] pat,
                         input int busy, input int wpct, input bit inject);
    logic [15:0] expw [0:255];
    bit keep_ok;
    for (int a = 0; a < 256; a++) begin
      regs[a] = 16'($urandom);
      keep[a] = 16'hFFFF;
    end
    regs[8'h3A][8] = 1'b0;
    for (int a = 0; a < 256; a++) snap[a] = regs[a];
    exp_chan = 16'(ch);
    plan_entry(0, 8'h3A, 16'h000C, 16'h0004);
    plan_entry(1, 8'hA1, 16'h0700, {5'd0, sz, 8'd0});
    plan_entry(2, 8'hA1, 16'h00FF, {8'd0, pat[39:32]});
    plan_entry(3, 8'hA2, 16'hFFFF, pat[31:16]);
    plan_entry(4, 8'hA3, 16'hFFFF, pat[15:0]);
    plan_entry(5, 8'hA1, 16'hC000, 16'h0000);
    plan_entry(6, 8'hA1, 16'h2000, 16'h0000);
    plan_entry(7, 8'hA1, 16'h0800, 16'h0000);
    plan_entry(8, 8'hA4, 16'h8000, (w < 2) ? 16'h8000 : 16'h0000);
    plan_entry(9, 8'hA6, 16'h0020, 16'h0000);
    plan_entry(10, 8'hB8, 16'h2000, 16'h0000);
    plan_entry(11, 8'hB9, 16'h0800, 16'h0000);
    plan_entry(12, 8'hBA, 16'h0800, 16'h0000);
    plan_entry(13, 8'hA0, 16'h0020, 16'h0020);
    keep[8'h38] = 16'h0000;
    keep[8'h3A] = 16'hFEFF;
    for (int i = 0; i < NRMW; i++) keep[pa[i]] = keep[pa[i]] & ~pm[i];
    phase = 0; done_cnt = 0; rst_cnt = 0;
    busy_left = busy; wait_pct = wpct;
    @(negedge clk);
    start = 1'b1; cfg_width = w; cfg_chan = ch; cfg_size = sz; cfg_pattern = pat;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      repeat (busy + 30) @(negedge clk);
      start = 1'b1; cfg_chan = ~ch; cfg_width = ~w; cfg_size = ~sz; cfg_pattern = ~pat;
      @(negedge clk);
      start = 1'b0;
    end
    for (int t = 0; t < 4000 && done_cnt == 0; t++) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(done_cnt == 1, (inject ? "R11" : "R10"), "single done per start", done_cnt, 1);
    chk(phase == LAST_PHASE, "R8", "all accesses seen", phase, LAST_PHASE);
    chk(regs[8'h38] == exp_chan, "R2", "channel register", regs[8'h38], exp_chan);
    chk(regs[8'h3A][3:2] == 2'b01, "R2", "mode field", regs[8'h3A][3:2], 1);
    chk(regs[8'hA1][10:8] == sz, "R4", "size field", regs[8'hA1][10:8], sz);
    chk(regs[8'hA1][7:0] == pat[39:32], "R4", "pattern top", regs[8'hA1][7:0], pat[39:32]);
    chk(regs[8'hA2] == pat[31:16], "R4", "pattern mid", regs[8'hA2], pat[31:16]);
    chk(regs[8'hA3] == pat[15:0], "R4", "pattern low", regs[8'hA3], pat[15:0]);
    chk({regs[8'hA1][15:13], regs[8'hA1][11]} == 4'b0, "R5", "aligner clears",
        {regs[8'hA1][15:13], regs[8'hA1][11]}, 0);
    chk(regs[8'hA4][15] == (w < 2), "R6", "sync disable bit", regs[8'hA4][15], (w < 2));
    chk({regs[8'hA6][5], regs[8'hB8][13], regs[8'hB9][11], regs[8'hBA][11]} == 4'b0,
        "R7", "enable clears",
        {regs[8'hA6][5], regs[8'hB8][13], regs[8'hB9][11], regs[8'hBA][11]}, 0);
    chk(regs[8'hA0][5] == 1'b1, "R7", "receive enable", regs[8'hA0][5], 1);
    keep_ok = 1'b1;
    for (int a = 0; a < 256; a++) begin
      expw[a] = snap[a] & keep[a];
      if ((regs[a] & keep[a]) != expw[a]) begin
        keep_ok = 1'b0;
        $display("FAIL R3 preserved bits at %0h: actual %0h expected %0h",
                 a, regs[a] & keep[a], expw[a]);
      end
    end
    chk(keep_ok, "R3", "untouched bits preserved", keep_ok, 1);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) regs[a] = '0;
    repeat (3) @(negedge clk);
    chk(!bus_rd && !bus_wr && !chan_rst && !done, "R10", "outputs in reset",
        {bus_rd, bus_wr, chan_rst, done}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!bus_rd && !bus_wr && !chan_rst && !done, "R10", "idle after reset",
        {bus_rd, bus_wr, chan_rst, done}, 0);
    run_seq(2'd2, 10'd5, 3'b101, 40'h00007FFFFF, 7, 30, 1'b0);
    run_seq(2'd0, 10'h3FF, 3'b010, {$urandom, $urandom}, 0, 0, 1'b0);
    run_seq(2'd1, 10'd17, 3'b111, {$urandom, $urandom}, 25, 60, 1'b1);
    run_seq(2'd3, 10'd200, 3'b000, 40'hFFFFFFFFFF, 3, 50, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule